// File: doc/BRIEF.md
# Serial Line Register Bank

This block sits between a processor register bus and a group of serial line engines. It gives every line four 16-bit registers: receive status, receive buffer, transmit status and transmit buffer. It keeps the done and interrupt-enable flags for each line. It records receive errors when a character arrives before the previous one was read. It starts a transmission in the external engine each time software writes the transmit buffer.

The line engines hand the block received characters through a one-cycle strobe per line, which can also mark a break. They report the end of a transmission with a done pulse. The block does no shifting, baud timing or character conversion. Interrupt requests leave the block as one-cycle set and clear strobes for each line and direction. An external arbiter keeps the pending state and picks the vector.

Bus accesses are single-cycle requests. Each request gets a registered response on the next cycle. An access whose address falls outside the configured lines is answered with an error flag instead of data.

Top module: `serial_reg_bank`

## Requirements
- R1: Each line owns an 8-byte window starting at BASE. The line is (address − BASE) >> 3, and address bits 2:1 pick the register: 0 receive status, 1 receive buffer, 2 transmit status, 3 transmit buffer. An address below BASE or at a line number of LINES or more gets an error response with read data 0 and changes no state.
- R2: The receive buffer reads data in bits 7:0, error in bit 15, overrun in bit 14 and break in bit 13. Both status registers carry done in bit 7 and interrupt enable in bit 6, and all other receive status bits read 0.
- R3: A character that arrives while receive done is clear is stored with all error bits clear, and receive done is set.
- R4: A character that arrives while receive done is still set replaces the stored data and is flagged with error and overrun. Receive done stays set.
- R5: A received break is stored as data 0 with error and break set.
- R6: Reading the receive buffer clears receive done and emits the receive clear strobe for that line. Reading any other register has no side effect.
- R7: Writing interrupt enable as 0 in either status register emits that side's clear strobe. Writing it as 1 while that side's done is set emits its set strobe. A received character emits the receive set strobe when receive interrupt enable is set.
- R8: Writes to the receive buffer are ignored, and so are writes to the odd byte of either status register. Address bit 0 set marks an odd-byte access.
- R9: Any write to the transmit buffer clears transmit done, emits the transmit clear strobe and pulses tx_start for that line. Only an even-byte write loads bits 7:0 into the buffer, which drives tx_char.
- R10: A tx_done pulse sets transmit done and emits the transmit set strobe if transmit interrupt enable is set.
- R11: Transmit status has read/write maintenance (bit 2) and transmit-break (bit 1) bits. After reset both buffers are 0, transmit done is 1, and every other flag is 0.
- R12: Every request is answered by bus_ack exactly one cycle later, with bus_rdata and bus_err valid in that cycle. Write responses return data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bit 0 marks an odd-byte access |
| bus_wdata | input | 16 | Write data |
| bus_ack | output | 1 | Response valid |
| bus_err | output | 1 | Address outside the configured lines |
| bus_rdata | output | 16 | Read data |
| rx_strobe | input | LINES | Character received, per line |
| rx_break | input | LINES | Qualifies rx_strobe as a break |
| rx_char | input | 8*LINES | Received character, 8 bits per line |
| tx_start | output | LINES | Start transmission pulse, per line |
| tx_char | output | 8*LINES | Transmit buffer contents, 8 bits per line |
| tx_done | input | LINES | Transmission complete pulse, per line |
| rx_irq_set | output | LINES | Raise receive request |
| rx_irq_clr | output | LINES | Withdraw receive request |
| tx_irq_set | output | LINES | Raise transmit request |
| tx_irq_clr | output | LINES | Withdraw transmit request |

## Verification
The bench goes after a second character landing on an unread buffer. A design that set done but left out overrun would report stale data as clean. It checks that enabling interrupts after done is already set raises a request. A design that only raised requests on new events would leave the line silent forever. Odd-byte writes to status and to the transmit buffer are covered: a design that decoded the odd byte as data would corrupt interrupt enable or the transmit character. Addresses just below BASE and just past the last line must return an error, or a neighbour's registers would alias.

// File: rtl/serial_reg_bank.sv
module serial_reg_bank #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = 12'h100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [15:0]         bus_wdata,
  output logic                bus_ack,
  output logic                bus_err,
  output logic [15:0]         bus_rdata,
  input  logic [LINES-1:0]    rx_strobe,
  input  logic [LINES-1:0]    rx_break,
  input  logic [8*LINES-1:0]  rx_char,
  output wire  [LINES-1:0]    tx_start,
  output wire  [8*LINES-1:0]  tx_char,
  input  logic [LINES-1:0]    tx_done,
  output wire  [LINES-1:0]    rx_irq_set,
  output wire  [LINES-1:0]    rx_irq_clr,
  output wire  [LINES-1:0]    tx_irq_set,
  output wire  [LINES-1:0]    tx_irq_clr
);
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [ADDR_W-4:0] NLINES = (ADDR_W-3)'(LINES);

  logic [ADDR_W-1:0] off;
  logic              in_rng;
  logic [LW-1:0]     idx;
  logic [1:0]        sel;
  logic              odd;

  assign off    = bus_addr - BASE;
  assign in_rng = (bus_addr >= BASE) && (off[ADDR_W-1:3] < NLINES);
  assign idx    = off[LW+2:3];
  assign sel    = bus_addr[2:1];
  assign odd    = bus_addr[0];

  wire [LINES-1:0] rxd_w, rxie_w, rxerr_w, rxovr_w, rxbrk_w;
  wire [LINES-1:0] txd_w, txie_w, txmnt_w, txbrk_w;
  wire [7:0]       rxdat_w [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic       rxd, rxie, rxerr, rxovr, rxbrk, txd, txie, txmnt, txbrk;
    logic [7:0] rxdat, txdat;
    logic       start_q, rset_q, rclr_q, tset_q, tclr_q;

    wire hit   = bus_req && in_rng && (idx == LW'(i));
    wire w_rxs = hit && bus_wr && sel == 2'd0 && !odd;
    wire r_rxb = hit && !bus_wr && sel == 2'd1;
    wire w_txs = hit && bus_wr && sel == 2'd2 && !odd;
    wire w_txb = hit && bus_wr && sel == 2'd3;
    wire rie_n = w_rxs ? bus_wdata[6] : rxie;
    wire tie_n = w_txs ? bus_wdata[6] : txie;
    wire rset  = (rx_strobe[i] && rie_n) || (w_rxs && bus_wdata[6] && rxd);
    wire rclr  = (r_rxb || (w_rxs && !bus_wdata[6])) && !rset;
    wire tset  = (tx_done[i] && !w_txb && tie_n) || (w_txs && bus_wdata[6] && txd);
    wire tclr  = (w_txb || (w_txs && !bus_wdata[6])) && !tset;
    wire ovr   = rxd && !r_rxb;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        {rxd, rxie, rxerr, rxovr, rxbrk} <= '0;
        {txie, txmnt, txbrk}             <= '0;
        txd   <= 1'b1;
        rxdat <= '0;
        txdat <= '0;
        {start_q, rset_q, rclr_q, tset_q, tclr_q} <= '0;
      end else begin
        if (w_rxs) rxie <= bus_wdata[6];
        if (rx_strobe[i]) begin
          rxdat <= rx_break[i] ? 8'h00 : rx_char[8*i +: 8];
          rxbrk <= rx_break[i];
          rxovr <= ovr;
          rxerr <= rx_break[i] || ovr;
          rxd   <= 1'b1;
        end else if (r_rxb) begin
          rxd <= 1'b0;
        end
        if (w_txs) {txie, txmnt, txbrk} <= {bus_wdata[6], bus_wdata[2], bus_wdata[1]};
        if (w_txb) begin
          if (!odd) txdat <= bus_wdata[7:0];
          txd <= 1'b0;
        end else if (tx_done[i]) begin
          txd <= 1'b1;
        end
        start_q <= w_txb;
        rset_q  <= rset;
        rclr_q  <= rclr;
        tset_q  <= tset;
        tclr_q  <= tclr;
      end
    end

    assign rxd_w[i] = rxd;   assign rxie_w[i] = rxie;
    assign rxerr_w[i] = rxerr; assign rxovr_w[i] = rxovr; assign rxbrk_w[i] = rxbrk;
    assign txd_w[i] = txd;   assign txie_w[i] = txie;
    assign txmnt_w[i] = txmnt; assign txbrk_w[i] = txbrk;
    assign rxdat_w[i] = rxdat;
    assign tx_char[8*i +: 8] = txdat;
    assign tx_start[i]   = start_q;
    assign rx_irq_set[i] = rset_q;
    assign rx_irq_clr[i] = rclr_q;
    assign tx_irq_set[i] = tset_q;
    assign tx_irq_clr[i] = tclr_q;

    AST_RX_DONE_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe[i] |=> rxd); // R3
    AST_OVR_HAS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      rxovr |-> rxerr); // R4
    AST_BRK_HAS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      rxbrk |-> (rxerr && rxdat == 8'h00)); // R5
    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start[i] |-> (!txd && tx_irq_clr[i])); // R9
    AST_RX_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_irq_set[i] && rx_irq_clr[i])); // R7
    AST_TX_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_irq_set[i] && tx_irq_clr[i])); // R7
  end

  logic [15:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (in_rng) begin
      case (sel)
        2'd0: rd_mux = {8'h00, rxd_w[idx], rxie_w[idx], 6'b0};
        2'd1: rd_mux = {rxerr_w[idx], rxovr_w[idx], rxbrk_w[idx], 5'b0, rxdat_w[idx]};
        2'd2: rd_mux = {8'h00, txd_w[idx], txie_w[idx], 3'b0, txmnt_w[idx], txbrk_w[idx], 1'b0};
        default: rd_mux = {8'h00, tx_char[8*idx +: 8]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req;
      bus_err   <= bus_req && !in_rng;
      bus_rdata <= (bus_req && !bus_wr) ? rd_mux : 16'h0000;
    end
  end

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack); // R12
  AST_ERR_ONLY_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_ack && bus_rdata == 16'h0000)); // R1
endmodule

// File: tb/sim_serial_reg_bank.sv
module sim_serial_reg_bank;
  localparam int L = 4;
  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic bus_ack, bus_err;
  logic [15:0] bus_rdata;
  logic [L-1:0] rx_strobe = '0, rx_break = '0, tx_done = '0;
  logic [8*L-1:0] rx_char = '0;
  wire [L-1:0] tx_start, rx_irq_set, rx_irq_clr, tx_irq_set, tx_irq_clr;
  wire [8*L-1:0] tx_char;

  serial_reg_bank u0 (.clk, .rst_n, .bus_req, .bus_wr, .bus_addr, .bus_wdata,
    .bus_ack, .bus_err, .bus_rdata, .rx_strobe, .rx_break, .rx_char,
    .tx_start, .tx_char, .tx_done, .rx_irq_set, .rx_irq_clr, .tx_irq_set, .tx_irq_clr);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [16:0] exp_q[$];
  string tag_q[$];
  logic [L-1:0] rs_log = '0, rc_log = '0, ts_log = '0, tc_log = '0, st_log = '0;

  always @(posedge clk) begin
    #1;
    rs_log |= rx_irq_set; rc_log |= rx_irq_clr;
    ts_log |= tx_irq_set; tc_log |= tx_irq_clr; st_log |= tx_start;
  end

  always @(negedge clk) begin
    if (rst_n && bus_ack) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({bus_err, bus_rdata} !== e) begin
        fails++;
        $display("FAIL %s: got err=%0b data=%h, expected err=%0b data=%h",
                 t, bus_err, bus_rdata, e[16], e[15:0]);
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h, expected %h", t, got, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [11:0] a, input logic [15:0] d,
                     input logic [15:0] er, input bit ee, input string t);
    @(negedge clk);
    bus_req = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    exp_q.push_back({ee, er}); tag_q.push_back(t);
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic rx(input int ln, input logic [7:0] c, input bit brk);
    @(negedge clk);
    rx_strobe[ln] = 1; rx_break[ln] = brk; rx_char[8*ln +: 8] = c;
    @(negedge clk);
    rx_strobe = '0; rx_break = '0;
  endtask

  task automatic txdone(input int ln);
    @(negedge clk); tx_done[ln] = 1;
    @(negedge clk); tx_done = '0;
  endtask

  task automatic clrlog();
    @(negedge clk);
    rs_log = '0; rc_log = '0; ts_log = '0; tc_log = '0; st_log = '0;
  endtask

  bit done = 0;
  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    acc(0, 12'h100, 0, 16'h0000, 0, "R11 rx status reset");
    acc(0, 12'h104, 0, 16'h0080, 0, "R11 tx status reset");
    acc(0, 12'h102, 0, 16'h0000, 0, "R11 rx buffer reset");
    acc(0, 12'h106, 0, 16'h0000, 0, "R11 tx buffer reset");
    // R1 range
    acc(0, 12'h0FE, 0, 16'h0000, 1, "R1 below base");
    acc(1, 12'h124, 16'h0040, 16'h0000, 1, "R1 past last line");
    acc(0, 12'h11C, 0, 16'h0080, 0, "R1 last line tx status");
    // R3 R6 line 1
    clrlog();
    rx(1, 8'h41, 0);
    acc(0, 12'h108, 0, 16'h0080, 0, "R3 done set");
    acc(0, 12'h10A, 0, 16'h0041, 0, "R2 R3 clean data");
    chk("R6 rx clear strobe", rc_log, 4'b0010);
    acc(0, 12'h108, 0, 16'h0000, 0, "R6 done cleared");
    chk("R7 no set without enable", rs_log, 4'b0000);
    // R4 overrun line 2
    rx(2, 8'h11, 0);
    rx(2, 8'h22, 0);
    acc(0, 12'h112, 0, 16'hC022, 0, "R4 overrun flags");
    // R5 break line 3
    rx(3, 8'h77, 1);
    acc(0, 12'h11A, 0, 16'hA000, 0, "R5 break flags");
    // R7 enable handling line 0
    clrlog();
    acc(1, 12'h100, 16'h0040, 16'h0000, 0, "R7 enable write");
    chk("R7 enable with done clear", rs_log | rc_log, 4'b0000);
    rx(0, 8'h55, 0);
    chk("R7 set on arrival", rs_log, 4'b0001);
    clrlog();
    acc(1, 12'h100, 16'h0000, 16'h0000, 0, "R7 disable write");
    chk("R7 clear on disable", rc_log, 4'b0001);
    clrlog();
    acc(1, 12'h100, 16'h0040, 16'h0000, 0, "R7 re-enable write");
    chk("R7 set on enable with done", rs_log, 4'b0001);
    acc(0, 12'h100, 0, 16'h00C0, 0, "R2 R7 rx status");
    // R8 ignored writes
    clrlog();
    acc(1, 12'h101, 16'h0000, 16'h0000, 0, "R8 odd status write");
    acc(0, 12'h100, 0, 16'h00C0, 0, "R8 status unchanged");
    chk("R8 no strobes", rs_log | rc_log, 4'b0000);
    acc(1, 12'h102, 16'h1234, 16'h0000, 0, "R8 rx buffer write");
    acc(0, 12'h102, 0, 16'h0055, 0, "R8 rx buffer unchanged");
    // R9 transmit line 1
    clrlog();
    acc(1, 12'h10E, 16'h01A5, 16'h0000, 0, "R9 tx buffer write");
    chk("R9 start pulse", st_log, 4'b0010);
    chk("R9 clear strobe", tc_log, 4'b0010);
    chk("R9 tx char", tx_char[15:8], 8'hA5);
    acc(0, 12'h10C, 0, 16'h0000, 0, "R9 tx done cleared");
    clrlog();
    acc(1, 12'h10F, 16'hFFFF, 16'h0000, 0, "R9 odd tx buffer write");
    chk("R9 odd write starts", st_log, 4'b0010);
    acc(0, 12'h10E, 0, 16'h00A5, 0, "R9 odd write keeps data");
    // R11 R10
    acc(1, 12'h10C, 16'h0046, 16'h0000, 0, "R11 tx status write");
    acc(0, 12'h10C, 0, 16'h0046, 0, "R11 maint and break bits");
    clrlog();
    txdone(1);
    chk("R10 set strobe", ts_log, 4'b0010);
    acc(0, 12'h10C, 0, 16'h00C6, 0, "R10 tx done set");
    // R7 tx side, line 2 idle
    clrlog();
    acc(1, 12'h114, 16'h0040, 16'h0000, 0, "R7 tx enable write");
    chk("R7 tx set when done", ts_log, 4'b0100);
    repeat (3) @(negedge clk);
    chk("R12 all responses seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule